// File: doc/BRIEF.md
# Cascadable Parallel-In Serial-Out Register

This block captures a word of parallel inputs and sends it out one bit per clock on a single serial line, so that a host can read many input lines through one data pin. A second serial pin accepts the output of another copy of the block. Chaining copies this way gives one long register that the host reads with the same pins, whatever the number of copies.

The block has two control pins, and both are active low. While the load pin is low, every clock edge copies the parallel inputs into the stages, and the enable and serial input have no effect. While the load pin is high and the enable is low, every clock edge moves the data one stage toward the serial output, and the first stage takes the serial input. With both control pins high the register keeps its contents. The serial output comes straight from the last stage. The most significant parallel bit therefore appears on it right after a load, and each shift brings out the next lower bit.

The pins are plain levels with no valid/ready handshake. Back-pressure is applied only by holding the enable high, which freezes the register for as long as the host needs.

Top module: `cascade_piso`

## Requirements
- R1: A clock edge with `rst_n` low clears every stage to 0, so `sop` reads 0 after reset and stays 0 while zeros are shifted in.
- R2: A clock edge with `ld_n` low copies `pip` into the stages, whatever the levels of `ce_n` and `sip`. Stage i takes `pip[i]`.
- R3: A shift happens only on a clock edge with `ld_n` high and `ce_n` low.
- R4: A clock edge with `ld_n` high and `ce_n` high leaves every stage unchanged, whatever `sip` does.
- R5: On a shift, stage 0 takes `sip` and each stage i takes the old value of stage i-1.
- R6: After a load, `sop` shows `pip[WIDTH-1]` first, then `pip[WIDTH-2]` down to `pip[0]` on successive shifts.
- R7: After WIDTH shifts following a load, `sop` shows the value that `sip` had at the first of those shifts.
- R8: `sop` is driven by the last stage and holds its new value from the clock edge that loads or shifts it until the next edge.
- R9: While `ld_n` stays low, the load repeats on every edge, so the stages follow a changing `pip`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears all stages |
| ld_n | input | 1 | Parallel load, active low; overrides the enable |
| ce_n | input | 1 | Shift enable, active low; used only while `ld_n` is high |
| sip | input | 1 | Serial input into stage 0, from the previous block in a chain |
| pip | input | WIDTH | Parallel data; bit WIDTH-1 leaves first |
| sop | output | 1 | Serial output from the last stage |

## Verification
The bench loads several words, including alternating, symmetric, all-ones, all-zeros and edge-only patterns, and shifts each one out. The order of the bits on `sop` shows whether the register shifts in the right direction and whether bit WIDTH-1 leaves first. A known run of `sip` bits is shifted in behind a loaded word, and the edge at which that run reaches `sop` confirms the length of the register and where the serial input enters. Hold cycles with `sip` toggling are placed inside a shift sequence, and loads are given with the enable low, the enable high and a changing `pip`. These cases show that the enable freezes the data and that the load overrides the enable.

// File: rtl/cascade_piso_pkg.sv
package cascade_piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } stage_op_e;
endpackage

// File: rtl/cascade_piso_ctrl.sv
module cascade_piso_ctrl
  import cascade_piso_pkg::*;
(
  input  logic      rst_n,
  input  logic      ld_n,
  input  logic      ce_n,
  output stage_op_e op
);
  // Priority: reset, then load (level), then enabled shift, else hold.
  always_comb begin
    if (!rst_n)     op = OP_CLEAR;
    else if (!ld_n) op = OP_LOAD;
    else if (!ce_n) op = OP_SHIFT;
    else            op = OP_HOLD;
  end
endmodule

// File: rtl/cascade_piso_cell.sv
module cascade_piso_cell
  import cascade_piso_pkg::*;
(
  input  logic      clk,
  input  stage_op_e op,
  input  logic      par_d,
  input  logic      ser_d,
  output logic      q
);
  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: q <= 1'b0;
      OP_LOAD:  q <= par_d;
      OP_SHIFT: q <= ser_d;
      default:  q <= q;
    endcase
  end
endmodule

// File: rtl/cascade_piso.sv
module cascade_piso
  import cascade_piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic             ce_n,
  input  logic             sip,
  input  logic [WIDTH-1:0] pip,
  output logic             sop
);
  localparam int LAST = WIDTH - 1;

  stage_op_e        op;
  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] ser_in;

  cascade_piso_ctrl u_ctrl (
    .rst_n (rst_n),
    .ld_n  (ld_n),
    .ce_n  (ce_n),
    .op    (op)
  );

  // Serial chain: stage 0 fed from sip, stage i from stage i-1.
  assign ser_in[0] = sip;
  generate
    if (WIDTH > 1) begin : g_chain
      assign ser_in[WIDTH-1:1] = stages[WIDTH-2:0];
    end
  endgenerate

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      cascade_piso_cell u_cell (
        .clk   (clk),
        .op    (op),
        .par_d (pip[i]),
        .ser_d (ser_in[i]),
        .q     (stages[i])
      );
    end
  endgenerate

  assign sop = stages[LAST];
endmodule

// File: rtl/cascade_piso_chk.sv
module cascade_piso_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_n,
  input logic             ce_n,
  input logic             sip,
  input logic [WIDTH-1:0] pip,
  input logic [WIDTH-1:0] stages,
  input logic             sop
);
  // R1: reset clears all stages
  p_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (stages == '0));

  // R2 / R9: load captures pip on every edge while ld_n is low
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> (stages == $past(pip)));

  // R8: after a load the output shows the top parallel bit
  p_load_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> (sop == $past(pip[WIDTH-1])));

  // R4: held contents do not move
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && ce_n) |=> $stable(stages));

  // R5: serial input enters stage 0 on a shift
  p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && !ce_n) |=> (stages[0] == $past(sip)));

  generate
    if (WIDTH > 1) begin : g_move
      // R3: on a shift the output takes the old second-to-last stage
      p_shift_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !ce_n) |=> (sop == $past(stages[WIDTH-2])));
    end
  endgenerate
endmodule

bind cascade_piso cascade_piso_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ld_n   (ld_n),
  .ce_n   (ce_n),
  .sip    (sip),
  .pip    (pip),
  .stages (stages),
  .sop    (sop)
);

// File: tb/sim_cascade_piso.sv
`timescale 1ns/1ps
module sim_cascade_piso;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_n = 1'b1;
  logic         ce_n = 1'b1;
  logic         sip = 1'b0;
  logic [W-1:0] pip = '0;
  logic         sop;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic  exp_q[$];
  string req_q[$];
  logic [W-1:0] model = '0;

  always #2 clk = ~clk;   // 250 MHz

  cascade_piso #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ce_n(ce_n),
    .sip(sip), .pip(pip), .sop(sop)
  );

  // Monitor: one expected item per clock edge, sampled 1 ns after it.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic  e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_checks++;
      if (sop !== e) begin
        n_fail++;
        $display("FAIL %s: sop=%0b expected %0b at %0t", r, sop, e, $time);
      end
    end
  end

  // Driver: set inputs for the next edge and push the expected sop.
  task automatic step(input logic rst, input logic ld, input logic ce,
                      input logic s, input logic [W-1:0] p, input string r);
    @(negedge clk);
    rst_n = rst; ld_n = ld; ce_n = ce; sip = s; pip = p;
    if (!rst)     model = '0;
    else if (!ld) model = p;
    else if (!ce) model = {model[W-2:0], s};
    exp_q.push_back(model[W-1]);
    req_q.push_back(r);
  endtask

  task automatic load_and_drain(input logic [W-1:0] p, input logic ce);
    step(1, 0, ce, ~p[0], p, "R8 load shows top bit");
    for (int i = 0; i < W - 1; i++)
      step(1, 1, 0, 1'b0, ~p, "R6 bit order after load");
  endtask

  initial begin
    // R1: reset state, then shifting zeros keeps output low
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1'b1, 8'hFF, "R1 reset");
    for (int i = 0; i < W; i++) step(1, 1, 0, 1'b0, 8'hFF, "R1 cleared stages");

    // R2: load with enable low and sip high is a plain load
    step(1, 0, 0, 1'b1, 8'hA5, "R2 load ignores ce_n and sip");
    // R3/R6: shift out with a marked sip run behind it
    step(1, 1, 0, 1'b1, 8'h00, "R3 shift");
    step(1, 1, 0, 1'b0, 8'h00, "R6 bit order");
    step(1, 1, 0, 1'b1, 8'h00, "R6 bit order");
    // R4: hold with sip toggling
    step(1, 1, 1, 1'b0, 8'hFF, "R4 hold");
    step(1, 1, 1, 1'b1, 8'h00, "R4 hold");
    step(1, 1, 1, 1'b0, 8'h5A, "R4 hold");
    for (int i = 0; i < 4; i++) step(1, 1, 0, i[0], 8'h00, "R6 bit order");
    // R5/R7: sip bits entered at shift 1.. appear after W shifts
    step(1, 1, 0, 1'b0, 8'h00, "R7 first sip at sop after W shifts");
    for (int i = 0; i < W - 1; i++) step(1, 1, 0, 1'b0, 8'h00, "R5 sip travels");

    // Several word patterns shifted out
    load_and_drain(8'h3C, 1'b0);
    load_and_drain(8'hFF, 1'b1);
    load_and_drain(8'h00, 1'b0);
    load_and_drain(8'h81, 1'b1);
    load_and_drain(8'h55, 1'b0);

    // R9: repeated load follows a changing pip
    step(1, 0, 1, 1'b0, 8'h80, "R9 repeated load");
    step(1, 0, 1, 1'b1, 8'h7F, "R9 repeated load");
    step(1, 0, 0, 1'b0, 8'hC0, "R9 repeated load");
    step(1, 0, 0, 1'b1, 8'h01, "R9 repeated load");
    // R3: enable high after load: nothing moves
    step(1, 1, 1, 1'b1, 8'hFF, "R3 no shift without enable");
    step(1, 1, 0, 1'b1, 8'hFF, "R3 shift");

    @(negedge clk);
    wait (exp_q.size() == 0);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule